// File: doc/BRIEF.md
# Memory-to-Memory Multi-Cycle Processor

This block is a small 16-bit processor with no register file. Every arithmetic instruction names two source words and one destination word directly in data memory. It runs each instruction as a fixed series of bus cycles on one shared address bus: fetch, decode, first operand read, second operand read, execute, and write-back. A holding register keeps the first operand while the second one travels over the same read path.

The read and write data paths are separate ports, but only one strobe is active in any cycle. A space-select output tells the memory system whether the address points at program space or at the 16-word data space. An 8-bit program counter walks program space. It moves to the next word after each instruction, or it is reloaded by a jump. A halt instruction parks the processor until reset.

Memory is expected to return read data one cycle after the read strobe. An arithmetic instruction takes six cycles. A jump, a no-op or a halt takes two cycles.

Top module: `mm_cpu`

## Requirements
- R1: An instruction word carries the opcode in bits 15:12, the first source address in 11:8, the second source address in 7:4 and the destination address in 3:0. Opcode 0x2 writes (first + second) mod 2^16 to the destination.
- R2: Opcode 0x3 writes (first - second) mod 2^16 to the destination.
- R3: Opcode 0x4 writes the first operand shifted left by the low 4 bits of the second operand. The upper 12 bits of the second operand are ignored, and bits shifted past bit 15 are lost.
- R4: An arithmetic instruction occupies exactly six cycles on the bus, in this order:
  - one program-space read at the PC;
  - one idle decode cycle;
  - a data read of the first source;
  - a data read of the second source;
  - one idle execute cycle;
  - one data write to the destination.
  Read data is taken one cycle after each read strobe.
- R5: The first operand is held stable while the second one is read, so an instruction is still correct when its sources and destination share an address.
- R6: Opcode 0x1 loads the PC with instruction bits 7:0. The next fetch is from that address, and no data access occurs. A jump takes two cycles.
- R7: Opcode 0x0 raises halt_o after two cycles. From then on, halt_o stays high and neither strobe is asserted until reset.
- R8: Opcodes 0x5 to 0xF make no data access, take two cycles and advance the PC by one.
- R9: The read and write strobes are never active together. Writes go only to data space (dspace_o = 1), and data-space addresses have bits 7:4 at zero.
- R10: While rst_ni is low, the PC is 0 and the controller sits in fetch: rd_o = 1, dspace_o = 0, addr_o = 0, wr_o = 0 and halt_o = 0.
- R11: After an arithmetic instruction or a no-op, the next fetch address is the previous PC plus one, modulo 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rdata_i | input | 16 | Read data, valid one cycle after rd_o |
| addr_o | output | 8 | Shared address for program and data accesses |
| dspace_o | output | 1 | 1 = data space, 0 = program space |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe (data space only) |
| wdata_o | output | 16 | Write data, valid while wr_o is high |
| halt_o | output | 1 | Processor halted |

## Verification
The embedded assertions check the following on every cycle:
- the strobes are exclusive and writes go only to data space;
- every write comes two cycles after a data read with an idle execute cycle in between;
- the held first operand does not move during write-back;
- halt is sticky;
- the fetch after a write-back or a jump uses the incremented PC or the jump target.

Only the bench's program runs can show that results are arithmetically right. Those runs cover addition and subtraction wrap, all sixteen shift amounts with the upper bits of the second operand set, aliased addresses, forward and backward jumps and every no-op opcode. The bench compares the final data memory, the cycle count to halt, and the numbers of data reads and writes against values it computes from the instruction stream.

// File: rtl/mm_cpu_pkg.sv
`timescale 1ns/1ps
package mm_cpu_pkg;
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_HALT = 4'h0;
  localparam logic [OPW-1:0] OP_JMP  = 4'h1;
  localparam logic [OPW-1:0] OP_ADD  = 4'h2;
  localparam logic [OPW-1:0] OP_SUB  = 4'h3;
  localparam logic [OPW-1:0] OP_SHL  = 4'h4;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_RD1, S_RD2, S_EXEC, S_WB, S_HALT
  } state_e;

  function automatic logic is_alu(input logic [OPW-1:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_SHL);
  endfunction
endpackage

// File: rtl/mm_alu.sv
`timescale 1ns/1ps
module mm_alu
  import mm_cpu_pkg::*;
#(
  parameter int DW = 16,
  parameter int SW = 4
) (
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  output logic [DW-1:0]  y_o
);
  always_comb begin
    unique case (op_i)
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      OP_SHL:  y_o = a_i << b_i[SW-1:0];
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/mm_ctrl.sv
`timescale 1ns/1ps
module mm_ctrl
  import mm_cpu_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [OPW-1:0] op_i,    // opcode seen on read data during decode
  output state_e         state_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_FETCH:  state_d = S_DECODE;
      S_DECODE: begin
        if (op_i == OP_HALT)   state_d = S_HALT;
        else if (is_alu(op_i)) state_d = S_RD1;
        else                   state_d = S_FETCH;
      end
      S_RD1:    state_d = S_RD2;
      S_RD2:    state_d = S_EXEC;
      S_EXEC:   state_d = S_WB;
      S_WB:     state_d = S_FETCH;
      S_HALT:   state_d = S_HALT;
      default:  state_d = S_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_FETCH;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R4: operand reads start only after an arithmetic opcode was decoded
  a_r4_rd1_after_alu_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RD1) |-> ($past(state_q) == S_DECODE) && is_alu($past(op_i)));
endmodule

// File: rtl/mm_cpu.sv
`timescale 1ns/1ps
module mm_cpu
  import mm_cpu_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int FW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic          dspace_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic [DW-1:0] wdata_o,
  output logic          halt_o
);
  localparam int S1_HI = 3*FW - 1;
  localparam int S2_HI = 2*FW - 1;
  localparam int AXW   = AW - FW;

  state_e          state;
  logic [AW-1:0]   pc_q;
  logic [DW-1:0]   ir_q, op1_q, res_q, alu_y;
  logic [OPW-1:0]  dec_op, ir_op;
  logic [FW-1:0]   src1, src2, dst;

  assign dec_op = rdata_i[DW-1 -: OPW];
  assign ir_op  = ir_q[DW-1 -: OPW];
  assign src1   = ir_q[S1_HI -: FW];
  assign src2   = ir_q[S2_HI -: FW];
  assign dst    = ir_q[FW-1:0];

  mm_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (dec_op),
    .state_o (state)
  );

  mm_alu #(.DW(DW), .SW(FW)) u_alu (
    .op_i (ir_op),
    .a_i  (op1_q),
    .b_i  (rdata_i),
    .y_o  (alu_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ir_q  <= '0;
      op1_q <= '0;
      res_q <= '0;
    end else begin
      unique case (state)
        S_DECODE: begin
          ir_q <= rdata_i;
          if (dec_op == OP_JMP)
            pc_q <= rdata_i[AW-1:0];
          else if (dec_op != OP_HALT && !is_alu(dec_op))
            pc_q <= pc_q + AW'(1);
        end
        S_RD2:   op1_q <= rdata_i;   // first operand held while second is read
        S_EXEC:  res_q <= alu_y;
        S_WB:    pc_q  <= pc_q + AW'(1);
        default: ;
      endcase
    end
  end

  // shared address bus source select
  always_comb begin
    addr_o   = '0;
    dspace_o = 1'b0;
    rd_o     = 1'b0;
    wr_o     = 1'b0;
    unique case (state)
      S_FETCH: begin addr_o = pc_q; rd_o = 1'b1; end
      S_RD1:   begin addr_o = {{AXW{1'b0}}, src1}; rd_o = 1'b1; dspace_o = 1'b1; end
      S_RD2:   begin addr_o = {{AXW{1'b0}}, src2}; rd_o = 1'b1; dspace_o = 1'b1; end
      S_WB:    begin addr_o = {{AXW{1'b0}}, dst};  wr_o = 1'b1; dspace_o = 1'b1; end
      default: ;
    endcase
  end

  assign wdata_o = res_q;
  assign halt_o  = (state == S_HALT);

  a_r9_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));

  a_r9_write_in_data_space: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> dspace_o && (addr_o[AW-1:FW] == '0));

  a_r4_write_after_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(rd_o, 2) && $past(dspace_o, 2) && !$past(rd_o, 1) && !$past(wr_o, 1));

  a_r5_op1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_WB) |-> $stable(op1_q));

  a_r7_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o && !rd_o && !wr_o);

  a_r11_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && !dspace_o && $past(wr_o)) |-> addr_o == $past(pc_q) + AW'(1));

  a_r6_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && !dspace_o && $past(state == S_DECODE) && $past(dec_op == OP_JMP))
      |-> addr_o == $past(rdata_i[AW-1:0]));
endmodule

// File: tb/sim_mm_cpu.sv
`timescale 1ns/1ps
module sim_mm_cpu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] rdata_i = '0;
  logic [7:0]  addr_o;
  logic        dspace_o, rd_o, wr_o, halt_o;
  logic [15:0] wdata_o;

  int checks = 0;
  int errors = 0;

  logic [15:0] imem [256];
  logic [15:0] dmem [16];
  logic [15:0] exp_d [16];
  int          n_drd = 0;
  int          n_dwr = 0;
  int unsigned seed = 32'h1234_5678;

  always #2 clk_i = ~clk_i;  // 250 MHz

  mm_cpu u0 (
    .clk_i, .rst_ni, .rdata_i, .addr_o, .dspace_o,
    .rd_o, .wr_o, .wdata_o, .halt_o
  );

  // memory model: one-cycle read latency
  always @(posedge clk_i) begin
    if (rd_o) begin
      rdata_i <= dspace_o ? dmem[addr_o[3:0]] : imem[addr_o];
      if (dspace_o) n_drd <= n_drd + 1;
    end
    if (wr_o && dspace_o) begin
      dmem[addr_o[3:0]] <= wdata_o;
      n_dwr <= n_dwr + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  function automatic logic [15:0] ins(input int op, input int a, input int b, input int d);
    return {op[3:0], a[3:0], b[3:0], d[3:0]};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) imem[i] = 16'h0000;
  endtask

  // instruction-level model: expected data memory, cycles and arithmetic count
  task automatic model(output int cyc, output int nalu);
    logic [15:0] em [16];
    logic [15:0] w, a, b, r;
    logic [7:0]  pc;
    for (int i = 0; i < 16; i++) em[i] = dmem[i];
    pc = 0; cyc = 0; nalu = 0;
    for (int step = 0; step < 2000; step++) begin
      w = imem[pc];
      cyc += 2;
      if (w[15:12] == 4'h0) break;
      if (w[15:12] == 4'h1) begin pc = w[7:0]; continue; end
      if (w[15:12] >= 4'h2 && w[15:12] <= 4'h4) begin
        a = em[w[11:8]]; b = em[w[7:4]];
        case (w[15:12])
          4'h2: r = a + b;
          4'h3: r = a - b;
          default: r = a << b[3:0];
        endcase
        em[w[3:0]] = r;
        cyc += 4;
        nalu++;
      end
      pc = pc + 8'd1;
    end
    for (int i = 0; i < 16; i++) exp_d[i] = em[i];
  endtask

  task automatic run(input string req);
    int ecyc, enalu, cyc, rd0, wr0;
    model(ecyc, enalu);
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(rd_o && !wr_o && !dspace_o && addr_o == 8'h00 && !halt_o, "R10",
        "reset state", {rd_o, wr_o, dspace_o, halt_o, addr_o}, 12'h800);
    rst_ni = 1'b1;
    rd0 = n_drd; wr0 = n_dwr; cyc = 0;
    for (int k = 0; k < 5000; k++) begin
      @(posedge clk_i);
      cyc++;
      @(negedge clk_i);
      if (halt_o) break;
    end
    chk(cyc == ecyc, req, "cycles to halt", cyc, ecyc);
    chk(n_dwr - wr0 == enalu, "R4", "data writes", n_dwr - wr0, enalu);
    chk(n_drd - rd0 == 2 * enalu, "R4", "data reads", n_drd - rd0, 2 * enalu);
    for (int i = 0; i < 16; i++)
      chk(dmem[i] === exp_d[i], req, $sformatf("dmem[%0d]", i), dmem[i], exp_d[i]);
    begin
      bit idle = 1'b1;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk_i);
        if (rd_o || wr_o || !halt_o) idle = 1'b0;
      end
      chk(idle, "R7", "halted idle", {rd_o, wr_o, halt_o}, 3'b001);
    end
  endtask

  task automatic fill_data(input logic [15:0] mul, input logic [15:0] x);
    for (int i = 0; i < 16; i++) dmem[i] = 16'(i) * mul ^ x;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected halt");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: additions over pseudo-random addresses
    for (int s = 0; s < 4; s++) begin
      clear_prog(); fill_data(16'h1357 + 16'(s), 16'hA5A5);
      for (int p = 0; p < 12; p++) imem[p] = ins(2, rnd(), rnd(), rnd());
      run("R1");
    end
    // R2: subtraction with wrap around zero and all-ones
    for (int s = 0; s < 4; s++) begin
      clear_prog(); fill_data(16'h0F0F, 16'h0000);
      dmem[0] = 16'h0000; dmem[15] = 16'hFFFF; dmem[1] = 16'h0001;
      imem[0] = ins(3, 0, 1, 2);
      imem[1] = ins(3, 0, 15, 3);
      for (int p = 2; p < 12; p++) imem[p] = ins(3, rnd(), rnd(), rnd());
      run("R2");
    end
    // R3: every shift amount, upper bits of the amount set
    for (int k = 0; k < 16; k++) begin
      clear_prog(); fill_data(16'h0101, 16'h0000);
      dmem[1] = 16'h8001 ^ 16'(k * 16'h0111);
      dmem[2] = 16'hFFF0 | 16'(k);
      imem[0] = ins(4, 1, 2, 3);
      run("R3");
    end
    // R5: aliased source and destination addresses
    clear_prog(); fill_data(16'h2345, 16'h1111);
    imem[0] = ins(2, 4, 4, 4);
    imem[1] = ins(3, 5, 5, 5);
    imem[2] = ins(2, 6, 7, 6);
    imem[3] = ins(3, 8, 9, 9);
    imem[4] = ins(4, 10, 11, 10);
    run("R5");
    // R6: forward and backward jumps skipping writes
    clear_prog(); fill_data(16'h0321, 16'h0000);
    imem[0] = ins(2, 1, 2, 3);
    imem[1] = 16'h1004;
    imem[2] = ins(3, 1, 2, 3);
    imem[3] = 16'h0000;
    imem[4] = ins(2, 3, 3, 5);
    imem[5] = 16'h1007;
    imem[6] = ins(2, 1, 1, 0);
    imem[7] = 16'h1003;
    run("R6");
    // R8: every no-op opcode interleaved with additions
    clear_prog(); fill_data(16'h0777, 16'h0005);
    for (int op = 5; op < 16; op++) begin
      imem[2*(op-5)]   = ins(op, rnd(), rnd(), rnd());
      imem[2*(op-5)+1] = ins(2, rnd(), rnd(), rnd());
    end
    run("R8");
    // R11: mixed programs, sequential PC stepping
    for (int s = 0; s < 20; s++) begin
      clear_prog(); fill_data(16'(rnd()), 16'(rnd()));
      for (int p = 0; p < 16; p++) begin
        int unsigned r = rnd() % 8;
        if (r == 5)                 imem[p] = ins(5 + int'(rnd() % 11), rnd(), rnd(), rnd());
        else if (r == 6 && p < 15)  imem[p] = {8'h10, 8'(p + 2)};
        else if (r == 0 || r == 7)  imem[p] = ins(3, rnd(), rnd(), rnd());
        else if (r == 1)            imem[p] = ins(4, rnd(), rnd(), rnd());
        else                        imem[p] = ins(2, rnd(), rnd(), rnd());
      end
      run("R11");
    end
    // R9: strobe exclusion is also covered by the embedded assertions
    chk(!(rd_o && wr_o), "R9", "strobes while halted", {rd_o, wr_o}, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule